// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses, for each conditional branch the fetch stage sees, whether it will be taken. It keeps one register holding the outcomes of the most recent resolved branches, and a table of two-bit saturating counters. The table entry for a branch is chosen by XOR-ing that outcome history with the low word-address bits of the branch PC. Two branches that share PC bits but arrive after different recent paths therefore land on different counters. This lets the table learn correlation between neighbouring branches.

The front end drives the branch PC bits and reads back a taken bit and the table index in the same cycle. It carries the index alongside the branch down the pipeline. When the branch resolves, the back end presents that same index with the actual outcome on the update port. The addressed counter trains one step toward the outcome, and the outcome is shifted into the history. Because the update uses the stored index and not the current history, later history shifts do not move the update onto another entry.

Top module: `gshare_predictor`

## Requirements
- R1: After reset the history holds all zeros and every counter holds 01 (weakly not taken). So any PC predicts not taken, and its index equals the PC bits. A single taken update to an entry then makes that entry predict taken.
- R2: The prediction index equals history XOR pred_pc. History bit 0 is the most recent update outcome and bit k is the outcome k updates earlier (1 = taken).
- R3: pred_taken is the most significant bit of the counter at the prediction index, combinationally in the same cycle: 10 and 11 predict taken, 00 and 01 predict not taken.
- R4: An update with upd_taken = 1 increments the counter at upd_idx, and a counter already at 11 stays at 11.
- R5: An update with upd_taken = 0 decrements the counter at upd_idx, and a counter already at 00 stays at 00. A counter at 11 that receives one not-taken update still predicts taken.
- R6: Each clock with upd_valid = 1 shifts upd_taken into history bit 0. A clock with upd_valid = 0 changes neither the history nor any counter, whatever upd_idx and upd_taken hold.
- R7: An update trains the counter named by upd_idx even after the history has moved on since that index was produced. The entry the current history would select is not touched.
- R8: When a prediction and an update address the same entry in one cycle, the prediction shows the counter value from before the update. The new value shows from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | HIST_W | Low word-address bits of the branch PC being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_idx | output | HIST_W | Table index used for this prediction, to be returned on update |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_idx | input | HIST_W | Index captured when the resolved branch was predicted |
| upd_taken | input | 1 | Actual outcome of the resolved branch, 1 = taken |

## Verification
Every cycle the assertions check four things: the history shifts in exactly the presented outcome, the history holds when no update is given, counters saturate at both ends, and the table reads weakly not taken straight after reset. Only the bench scenarios can show the rest. These are the full train-and-predict sequence through all four counter states across a changing history, the routing of a stale index to its original entry, and that a same-cycle collision reads the old value. Each of these depends on a chain of earlier updates, not on one cycle's relation.

// File: rtl/gshare_pkg.sv
`timescale 1ns/1ps
package gshare_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;

  // One training step of a two-bit saturating counter.
  function automatic ctr_t ctr_train(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_ST)  ? CTR_ST  : ctr_t'(cur + 2'd1);
    else       nxt = (cur == CTR_SNT) ? CTR_SNT : ctr_t'(cur - 2'd1);
    return nxt;
  endfunction

  function automatic logic ctr_dir(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/gs_history.sv
`timescale 1ns/1ps
module gs_history #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] hist_q
);

  always_ff @(posedge clk) begin
    if (rst)           hist_q <= '0;
    else if (shift_en) hist_q <= {hist_q[W-2:0], bit_in};
  end

  // R6: the newest outcome lands in bit 0 and older ones move up by one
  p_shift_in_r6: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (hist_q[0] == $past(bit_in)) && (hist_q[W-1:1] == $past(hist_q[W-2:0])));

  // R6: without an update the history does not move
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist_q));

endmodule

// File: rtl/gs_index.sv
`timescale 1ns/1ps
module gs_index #(
  parameter int W = 10
) (
  input  logic [W-1:0] hist,
  input  logic [W-1:0] pc,
  output logic [W-1:0] idx
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign idx[b] = hist[b] ^ pc[b];
  end

endmodule

// File: rtl/gs_pht.sv
`timescale 1ns/1ps
module gs_pht
  import gshare_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int DEPTH = 1 << IDX_W;

  ctr_t tbl [DEPTH];

  // Read before write: a same-cycle update is seen from the next cycle on.
  assign rd_ctr = tbl[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= CTR_WNT;
    end else if (wr_en) begin
      tbl[wr_idx] <= ctr_train(tbl[wr_idx], wr_taken);
    end
  end

  // R4: a strongly taken counter stays put on another taken outcome
  p_sat_top_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && tbl[wr_idx] == CTR_ST) |=> tbl[$past(wr_idx)] == CTR_ST);

  // R5: a strongly not-taken counter stays put on another not-taken outcome
  p_sat_bottom_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && tbl[wr_idx] == CTR_SNT) |=> tbl[$past(wr_idx)] == CTR_SNT);

endmodule

// File: rtl/gshare_predictor.sv
`timescale 1ns/1ps
module gshare_predictor
  import gshare_pkg::*;
#(
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HIST_W-1:0] pred_pc,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_idx,
  input  logic              upd_valid,
  input  logic [HIST_W-1:0] upd_idx,
  input  logic              upd_taken
);

  logic [HIST_W-1:0] hist;
  ctr_t              rd_ctr;

  gs_history #(.W(HIST_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (upd_valid),
    .bit_in   (upd_taken),
    .hist_q   (hist)
  );

  gs_index #(.W(HIST_W)) u_index (
    .hist (hist),
    .pc   (pred_pc),
    .idx  (pred_idx)
  );

  gs_pht #(.IDX_W(HIST_W)) u_pht (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (pred_idx),
    .rd_ctr   (rd_ctr),
    .wr_en    (upd_valid),
    .wr_idx   (upd_idx),
    .wr_taken (upd_taken)
  );

  assign pred_taken = ctr_dir(rd_ctr);

  // R1: straight after reset release the whole table reads not taken
  p_reset_nt_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !pred_taken);

endmodule

// File: tb/tb_gshare_predictor.sv
`timescale 1ns/1ps
module tb_gshare_predictor;

  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] pred_pc = '0;
  logic         pred_taken;
  logic [W-1:0] pred_idx;
  logic         upd_valid = 1'b0;
  logic [W-1:0] upd_idx = '0;
  logic         upd_taken = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gshare_predictor #(.HIST_W(W)) dut (
    .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_idx(pred_idx), .upd_valid(upd_valid), .upd_idx(upd_idx),
    .upd_taken(upd_taken)
  );

  // {pc, outcome, expected prediction, expected index}
  localparam int NV = 13;
  localparam logic [2*W+1:0] VEC [NV] = '{
    {10'h005, 1'b1, 1'b0, 10'h005},
    {10'h004, 1'b1, 1'b1, 10'h005},
    {10'h006, 1'b0, 1'b1, 10'h005},
    {10'h003, 1'b0, 1'b1, 10'h005},
    {10'h009, 1'b0, 1'b0, 10'h005},
    {10'h01D, 1'b0, 1'b0, 10'h005},
    {10'h035, 1'b1, 1'b0, 10'h005},
    {10'h064, 1'b1, 1'b0, 10'h005},
    {10'h0C6, 1'b1, 1'b1, 10'h005},
    {10'h182, 1'b1, 1'b1, 10'h005},
    {10'h30A, 1'b0, 1'b1, 10'h005},
    {10'h21B, 1'b1, 1'b1, 10'h005},
    {10'h03D, 1'b0, 1'b0, 10'h000}
  };

  task automatic check(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    upd_valid = 1'b0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  // Drive a PC at the falling edge and sample 1 ns before the rising edge.
  task automatic probe(input logic [W-1:0] pc, output logic p, output logic [W-1:0] ix);
    @(negedge clk);
    pred_pc = pc;
    #1;
    p  = pred_taken;
    ix = pred_idx;
  endtask

  task automatic commit(input logic [W-1:0] ix, input logic tk);
    upd_valid = 1'b1;
    upd_idx   = ix;
    upd_taken = tk;
    @(posedge clk);
    #1 upd_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic         p;
    logic [W-1:0] ix;
    logic [W-1:0] saved;

    do_reset();

    // R2 R3 R4 R5: walk a counter through all states under changing history
    for (int v = 0; v < NV; v++) begin
      logic [W-1:0] vpc, vix;
      logic         vtk, vp;
      {vpc, vtk, vp, vix} = VEC[v];
      probe(vpc, p, ix);
      check(int'(ix), int'(vix), $sformatf("R2 vec%0d index", v));
      check(int'(p), int'(vp), $sformatf("R3 R4 R5 vec%0d prediction", v));
      commit(ix, vtk);
    end

    // R1: reset clears history and returns counters to weakly not taken
    do_reset();
    probe(10'h005, p, ix);
    check(int'(p), 0, "R1 pc 005 prediction");
    check(int'(ix), 10'h005, "R1 pc 005 index");
    probe(10'h3FF, p, ix);
    check(int'(p), 0, "R1 pc 3FF prediction");
    check(int'(ix), 10'h3FF, "R1 pc 3FF index");
    commit(10'h005, 1'b1);
    probe(10'h004, p, ix);
    check(int'(ix), 10'h005, "R1 index after one taken");
    check(int'(p), 1, "R1 one step from weakly not taken");

    // R7: a stale index still trains its own entry
    do_reset();
    probe(10'h010, p, ix);
    saved = ix;
    check(int'(saved), 10'h010, "R7 captured index");
    commit(10'h200, 1'b1);
    commit(10'h201, 1'b1);
    commit(saved, 1'b1);
    commit(saved, 1'b1);
    probe(10'h01F, p, ix);
    check(int'(ix), 10'h010, "R7 index of stale entry");
    check(int'(p), 1, "R7 stale entry trained");
    probe(10'h01C, p, ix);
    check(int'(ix), 10'h013, "R7 index of redirected entry");
    check(int'(p), 0, "R7 redirected entry untouched");

    // R6: idle update inputs change nothing
    do_reset();
    commit(10'h100, 1'b1);
    upd_idx   = 10'h100;
    upd_taken = 1'b0;
    repeat (4) @(posedge clk);
    probe(10'h000, p, ix);
    check(int'(ix), 10'h001, "R6 history after one update and idle cycles");
    probe(10'h101, p, ix);
    check(int'(ix), 10'h100, "R6 index of trained entry");
    check(int'(p), 1, "R6 counter unchanged while idle");

    // R8: same-cycle prediction and update read the old value
    do_reset();
    @(negedge clk);
    pred_pc   = 10'h040;
    upd_valid = 1'b1;
    upd_idx   = 10'h040;
    upd_taken = 1'b1;
    #1;
    check(int'(pred_taken), 0, "R8 collision reads old value");
    check(int'(pred_idx), 10'h040, "R8 collision index");
    @(posedge clk);
    #1 upd_valid = 1'b0;
    probe(10'h041, p, ix);
    check(int'(ix), 10'h040, "R8 index next cycle");
    check(int'(p), 1, "R8 new value next cycle");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule